// File: doc/BRIEF.md
# Dual-Mode Timer and Event Counter

This block is a byte-oriented count peripheral of the kind found beside a small 8-bit processor core. It keeps a count held in a high byte and a low byte. It advances that count either once per machine cycle (timer use) or once per qualified falling edge on an external event pin (counter use). A software run bit and an optional hardware gate input decide whether counting is allowed. The gate makes it possible to measure how long an external signal stays high. An overflow flag records a wrap of the count. The flag stays set until software clears it or the interrupt logic acknowledges it.

The machine-cycle strobe `mc_tick` is one clock wide and marks the single sampling phase of each machine cycle. A 2-bit mode field chooses the count layout. Mode 00 is a 13-bit count made of the whole high byte and the low five bits of the low byte. Mode 01 is a full 16-bit count. Mode 10 is an 8-bit counter in the low byte that reloads from the high byte. Mode 11 belongs to a split arrangement that pairs two instances, so a single instance holds its count in that mode. Software reads both count bytes on the output ports and writes either byte through a small write port.

Top module: `evtmr_top`

## Requirements
- R1: While `rst_n` is low and after its release, both count bytes and the overflow flag are 0.
- R2: With `ct_sel`=0 (timer) and counting enabled, the count advances by exactly one for each clock in which `mc_tick` is 1. The new value is visible after that clock edge.
- R3: With `ct_sel`=1 (counter), `ev_in` is sampled only in clocks with `mc_tick`=1. A count occurs only when one sample is 1 and the next sample is 0. The count changes one clock after the sampling edge that found the low level. A rising transition never counts. A level that toggles every machine cycle yields one count per two machine cycles.
- R4: Counting is enabled only when `run`=1 and either `gate_en`=0 or `gate_in`=1. Otherwise the count holds.
- R5: In mode 00 the count is {high byte, low byte bits 4:0}. Low bits 4:0 carrying from 0x1F clear to 0 and increment the high byte. The step from 0x1FFF wraps to 0 and sets the flag. Low byte bits 7:5 are never changed by counting.
- R6: In mode 01 the count is {high byte, low byte}. The step from 0xFFFF gives 0x0000 and sets the flag.
- R7: In mode 10 the low byte counts. A step from 0xFF loads the low byte with the high byte and sets the flag. Counting never changes the high byte.
- R8: In mode 11 counting events leave both bytes unchanged.
- R9: The overflow flag stays 1 until a clock with `ovf_clr`=1 or `int_ack`=1. If a wrap and a clear fall in the same clock, the flag ends at 1.
- R10: A clock with `bus_we`=1 loads `bus_wdata` into the low byte (`bus_sel`=0) or the high byte (`bus_sel`=1). No counting step and no flag setting happens in that clock.
- R11: Changing `run` from 0 to 1 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | One-clock strobe at the sampling phase of each machine cycle |
| mode | input | 2 | Count layout: 00 13-bit, 01 16-bit, 10 8-bit reload, 11 hold |
| ct_sel | input | 1 | 0 counts machine cycles, 1 counts external falling edges |
| gate_en | input | 1 | When 1, counting also needs `gate_in` high |
| run | input | 1 | Software run control |
| gate_in | input | 1 | External gate level |
| ev_in | input | 1 | External event pin, synchronous to `clk` |
| bus_we | input | 1 | Write strobe for a count byte |
| bus_sel | input | 1 | Byte select: 0 low, 1 high |
| bus_wdata | input | 8 | Write data |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| int_ack | input | 1 | Interrupt acknowledge, also clears the flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest situations to reach from the ports involve a bus write or a flag clear landing in exactly the clock of a counting step. This matters most at a wrap point, where both the count priority and the flag priority are decided. The bench drives `mc_tick` itself rather than from a free-running divider. It can therefore raise the strobe in the same clock as `bus_we` or `ovf_clr`, after first preloading the count to 0xFFFF through the write port. The one-clock latency in counter use is checked in a similar way. The bench samples between the detecting strobe edge and the next edge, so it can see that the count has not yet moved.

// File: rtl/evtmr_pkg.sv
// Package: shared types of the timer/event counter.
// Assumes: mode encodings are fixed by the register field layout.
package evtmr_pkg;
    typedef enum logic [1:0] {
        MD_13BIT = 2'b00,
        MD_16BIT = 2'b01,
        MD_RELOAD = 2'b10,
        MD_SPLIT = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/evtmr_sampler.sv
// Samples the external event pin once per machine cycle and emits a
// one-clock pulse in the clock after a high sample is followed by a low one.
// Assumes: ev_in is already synchronous to clk; mc_tick is one clock wide.
module evtmr_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic ev_in,
    output logic fall_pulse
);
    logic last_smp;

    // Hold the previous sample and flag a high-to-low pair of samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_smp   <= 1'b0;
            fall_pulse <= 1'b0;
        end else begin
            fall_pulse <= mc_tick & last_smp & ~ev_in;
            if (mc_tick) begin
                last_smp <= ev_in;
            end
        end
    end
endmodule

// File: rtl/evtmr_enable.sv
// Chooses the counting event source and applies the run/gate qualification.
// Assumes: gate_in is synchronous to clk.
module evtmr_enable (
    input  logic mc_tick,
    input  logic fall_pulse,
    input  logic ct_sel,
    input  logic run,
    input  logic gate_en,
    input  logic gate_in,
    output logic step
);
    logic allowed;

    // Step when the selected event occurs and counting is permitted.
    always_comb begin
        allowed = run & (~gate_en | gate_in);
        step    = allowed & (ct_sel ? fall_pulse : mc_tick);
    end
endmodule

// File: rtl/evtmr_count.sv
// Count registers and overflow flag for all count layouts.
// Assumes: step is a one-clock pulse; a bus write overrides a step.
module evtmr_count
    import evtmr_pkg::*;
#(
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int PRE_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [1:0]      mode,
    input  logic            bus_we,
    input  logic            bus_sel,
    input  logic [LO_W-1:0] bus_wdata,
    input  logic            ovf_clr,
    input  logic            int_ack,
    output logic [LO_W-1:0] lo_q,
    output logic [HI_W-1:0] hi_q,
    output logic            flag_q
);
    localparam int CNT_W = LO_W + HI_W;

    tmr_mode_e       md;
    logic [LO_W-1:0] lo_nxt;
    logic [HI_W-1:0] hi_nxt;
    logic [CNT_W-1:0] full_nxt;
    logic            wrap;

    // Next count and wrap indication for one step in the selected layout.
    always_comb begin
        md       = tmr_mode_e'(mode);
        lo_nxt   = lo_q;
        hi_nxt   = hi_q;
        wrap     = 1'b0;
        full_nxt = {hi_q, lo_q} + CNT_W'(1);
        case (md)
            MD_13BIT: begin
                if (&lo_q[PRE_W-1:0]) begin
                    lo_nxt[PRE_W-1:0] = {PRE_W{1'b0}};
                    hi_nxt            = hi_q + HI_W'(1);
                    wrap              = &hi_q;
                end else begin
                    lo_nxt[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
                end
            end
            MD_16BIT: begin
                {hi_nxt, lo_nxt} = full_nxt;
                wrap             = &{hi_q, lo_q};
            end
            MD_RELOAD: begin
                if (&lo_q) begin
                    lo_nxt = LO_W'(hi_q);
                    wrap   = 1'b1;
                end else begin
                    lo_nxt = lo_q + LO_W'(1);
                end
            end
            default: begin
                lo_nxt = lo_q;
                hi_nxt = hi_q;
            end
        endcase
    end

    // Count bytes: reset, then bus write, then counting step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (bus_we) begin
            if (bus_sel) hi_q <= HI_W'(bus_wdata);
            else         lo_q <= bus_wdata;
        end else if (step) begin
            lo_q <= lo_nxt;
            hi_q <= hi_nxt;
        end
    end

    // Sticky overflow flag: a wrap wins over a clear in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (step && wrap && !bus_we) begin
            flag_q <= 1'b1;
        end else if (ovf_clr || int_ack) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evtmr_top.sv
// Timer/event counter top: pin sampler, enable logic and count registers.
// Assumes: all inputs are synchronous to clk; mc_tick marks one clock per
// machine cycle.
module evtmr_top #(
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int PRE_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_tick,
    input  logic [1:0]      mode,
    input  logic            ct_sel,
    input  logic            gate_en,
    input  logic            run,
    input  logic            gate_in,
    input  logic            ev_in,
    input  logic            bus_we,
    input  logic            bus_sel,
    input  logic [LO_W-1:0] bus_wdata,
    input  logic            ovf_clr,
    input  logic            int_ack,
    output logic [LO_W-1:0] cnt_lo,
    output logic [HI_W-1:0] cnt_hi,
    output logic            ovf_flag
);
    logic fall_pulse;
    logic step;

    evtmr_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_tick    (mc_tick),
        .ev_in      (ev_in),
        .fall_pulse (fall_pulse)
    );

    evtmr_enable u_en (
        .mc_tick    (mc_tick),
        .fall_pulse (fall_pulse),
        .ct_sel     (ct_sel),
        .run        (run),
        .gate_en    (gate_en),
        .gate_in    (gate_in),
        .step       (step)
    );

    evtmr_count #(.LO_W(LO_W), .HI_W(HI_W), .PRE_W(PRE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .mode      (mode),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .ovf_clr   (ovf_clr),
        .int_ack   (int_ack),
        .lo_q      (cnt_lo),
        .hi_q      (cnt_hi),
        .flag_q    (ovf_flag)
    );
endmodule

// File: rtl/evtmr_chk.sv
// Checker for evtmr_top, attached by bind; observes ports only.
module evtmr_chk #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mc_tick,
    input logic [1:0]      mode,
    input logic            ct_sel,
    input logic            gate_en,
    input logic            run,
    input logic            gate_in,
    input logic            bus_we,
    input logic            bus_sel,
    input logic [LO_W-1:0] bus_wdata,
    input logic            ovf_clr,
    input logic            int_ack,
    input logic [LO_W-1:0] cnt_lo,
    input logic [HI_W-1:0] cnt_hi,
    input logic            ovf_flag
);
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !ct_sel && run && !gate_en && mc_tick && !bus_we)
        |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1)); // R2

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_we) |=> $stable({cnt_hi, cnt_lo})); // R4

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !gate_in && !bus_we) |=> $stable({cnt_hi, cnt_lo})); // R4

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !bus_we) |=> $stable(cnt_lo[LO_W-1:5])); // R5

    AST_RELOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !bus_we) |=> $stable(cnt_hi)); // R7

    AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !bus_we) |=> $stable({cnt_hi, cnt_lo})); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr && !int_ack) |=> ovf_flag); // R9

    AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_sel) |=> (cnt_lo == $past(bus_wdata))); // R10

    AST_WRITE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !ovf_flag) |=> !ovf_flag); // R10
endmodule

bind evtmr_top evtmr_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_tick   (mc_tick),
    .mode      (mode),
    .ct_sel    (ct_sel),
    .gate_en   (gate_en),
    .run       (run),
    .gate_in   (gate_in),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .ovf_clr   (ovf_clr),
    .int_ack   (int_ack),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .ovf_flag  (ovf_flag)
);

// File: tb/tb_evtmr_top.sv
// Directed bench for evtmr_top: one task per scenario, each self-checking.
module tb_evtmr_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       ct_sel = 1'b0;
    logic       gate_en = 1'b0;
    logic       run = 1'b0;
    logic       gate_in = 1'b0;
    logic       ev_in = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       ovf_clr = 1'b0;
    logic       int_ack = 1'b0;
    logic [7:0] cnt_lo;
    logic [7:0] cnt_hi;
    logic       ovf_flag;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    evtmr_top dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .mode(mode),
        .ct_sel(ct_sel), .gate_en(gate_en), .run(run), .gate_in(gate_in),
        .ev_in(ev_in), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .ovf_clr(ovf_clr), .int_ack(int_ack),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One machine cycle: strobe for one clock, then idle clocks.
    task automatic tick();
        @(negedge clk); mc_tick = 1'b1;
        @(negedge clk); mc_tick = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 count in reset", {cnt_hi, cnt_lo}, 32'h0);
        chk("R1 flag in reset", ovf_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after release", {cnt_hi, cnt_lo}, 32'h0);
    endtask

    task automatic t_timer();
        mode = 2'b01; ct_sel = 1'b0; gate_en = 1'b0; run = 1'b1;
        repeat (5) tick();
        chk("R2 five machine cycles", {cnt_hi, cnt_lo}, 32'h0005);
        @(negedge clk); mc_tick = 1'b1;
        @(negedge clk); mc_tick = 1'b0;
        chk("R2 visible after strobe edge", {cnt_hi, cnt_lo}, 32'h0006);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_enable();
        run = 1'b0;
        repeat (3) tick();
        chk("R4 run low holds", {cnt_hi, cnt_lo}, 32'h0006);
        run = 1'b1;
        @(negedge clk);
        chk("R11 run set keeps count", {cnt_hi, cnt_lo}, 32'h0006);
        gate_en = 1'b1; gate_in = 1'b0;
        repeat (3) tick();
        chk("R4 gate low holds", {cnt_hi, cnt_lo}, 32'h0006);
        gate_in = 1'b1;
        repeat (2) tick();
        chk("R4 gate high counts", {cnt_hi, cnt_lo}, 32'h0008);
        gate_en = 1'b0; gate_in = 1'b0;
        tick();
        chk("R4 gate disabled counts", {cnt_hi, cnt_lo}, 32'h0009);
    endtask

    task automatic t_wrap16();
        mode = 2'b01; run = 1'b0;
        wr(1'b0, 8'hFE); wr(1'b1, 8'hFF);
        run = 1'b1;
        tick();
        chk("R6 reach FFFF", {ovf_flag, cnt_hi, cnt_lo}, 32'h0FFFF);
        tick();
        chk("R6 wrap to zero with flag", {ovf_flag, cnt_hi, cnt_lo}, 32'h10000);
        repeat (2) tick();
        chk("R9 flag stays set", ovf_flag, 1'b1);
        clear_flag();
        chk("R9 software clear", ovf_flag, 1'b0);
    endtask

    task automatic t_mode13();
        mode = 2'b00; run = 1'b0;
        wr(1'b0, 8'h1F); wr(1'b1, 8'h05);
        run = 1'b1;
        tick();
        chk("R5 carry into high byte", {cnt_hi, cnt_lo}, 32'h0600);
        run = 1'b0;
        wr(1'b0, 8'hFE); wr(1'b1, 8'hFF);
        run = 1'b1;
        tick();
        chk("R5 reach 1FFF", {ovf_flag, cnt_hi, cnt_lo}, 32'h0FFFF);
        tick();
        chk("R5 wrap keeps upper low bits, sets flag", {ovf_flag, cnt_hi, cnt_lo}, 32'h100E0);
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
        chk("R9 acknowledge clears", ovf_flag, 1'b0);
    endtask

    task automatic t_reload();
        mode = 2'b10; run = 1'b0;
        wr(1'b0, 8'hFD); wr(1'b1, 8'h80);
        run = 1'b1;
        repeat (2) tick();
        chk("R7 low byte counts", {ovf_flag, cnt_hi, cnt_lo}, 32'h080FF);
        tick();
        chk("R7 reload from high byte", {ovf_flag, cnt_hi, cnt_lo}, 32'h18080);
        tick();
        chk("R7 counts on from reload", {cnt_hi, cnt_lo}, 32'h8081);
        clear_flag();
    endtask

    task automatic t_split();
        mode = 2'b11;
        repeat (3) tick();
        chk("R8 mode 11 holds", {ovf_flag, cnt_hi, cnt_lo}, 32'h08081);
    endtask

    task automatic t_counter();
        mode = 2'b01; ct_sel = 1'b1; run = 1'b0;
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        run = 1'b1;
        ev_in = 1'b1; tick();
        ev_in = 1'b0;
        @(negedge clk); mc_tick = 1'b1;
        @(negedge clk); mc_tick = 1'b0;
        chk("R3 no change at detecting edge", {cnt_hi, cnt_lo}, 32'h0000);
        @(negedge clk);
        chk("R3 count one clock later", {cnt_hi, cnt_lo}, 32'h0001);
        repeat (9) @(negedge clk);
        ev_in = 1'b1; repeat (2) tick();
        chk("R3 rising edge ignored", {cnt_hi, cnt_lo}, 32'h0001);
        for (int i = 0; i < 8; i++) begin
            ev_in = (i % 2 == 0) ? 1'b0 : 1'b1;
            tick();
        end
        chk("R3 toggling gives half rate", {cnt_hi, cnt_lo}, 32'h0005);
        ct_sel = 1'b0;
    endtask

    task automatic t_priority();
        mode = 2'b01; run = 1'b1;
        wr(1'b0, 8'h10); wr(1'b1, 8'h00);
        @(negedge clk); mc_tick = 1'b1; bus_we = 1'b1; bus_sel = 1'b0; bus_wdata = 8'h55;
        @(negedge clk); mc_tick = 1'b0; bus_we = 1'b0;
        chk("R10 write beats step", {cnt_hi, cnt_lo}, 32'h0055);
        run = 1'b0;
        wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
        run = 1'b1;
        @(negedge clk); mc_tick = 1'b1; bus_we = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h12;
        @(negedge clk); mc_tick = 1'b0; bus_we = 1'b0;
        chk("R10 write at wrap, no flag", {ovf_flag, cnt_hi, cnt_lo}, 32'h012FF);
        run = 1'b0;
        wr(1'b1, 8'hFF);
        run = 1'b1;
        @(negedge clk); mc_tick = 1'b1; ovf_clr = 1'b1;
        @(negedge clk); mc_tick = 1'b0; ovf_clr = 1'b0;
        chk("R9 set wins over clear", {ovf_flag, cnt_hi, cnt_lo}, 32'h10000);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_enable();
        t_wrap16();
        t_mode13();
        t_reload();
        t_split();
        t_counter();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule